// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block runs one atomic memory instruction at a time against a synchronous single-port memory. A command carries the opcode byte, the 32-bit operation immediate, the base address taken from the destination register, a signed 16-bit displacement, the source register value and the value of register zero. Once the command is accepted the unit asks for the memory lock. With the lock granted it reads the target, computes the new value, writes it back and then drops the lock. No other requester can touch memory between the read and the write.

The unit returns a response with optional write-back values for the source register and for register zero, plus a flag for an illegal encoding. Commands enter on a valid/ready channel. `cmd_ready` is high only while the unit is idle, so a command is taken on the edge where `cmd_valid` and `cmd_ready` are both high. The response is offered on `rsp_valid`. It stays valid and unchanged until `rsp_ready` is seen high at a clock edge, and no new command is accepted before then. The lock request, grant and memory pins are plain control signals.

The memory takes a read or write when `mem_en` is high at a clock edge. Read data appears on `mem_rdata` in the following cycle. Word accesses use bits 31:0 of the data buses.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Only opcode 0xC3 (word, 32-bit) and 0xDB (double word, 64-bit) are legal. Any other opcode is reported as illegal.
- R2: The memory address is the base plus the 16-bit displacement, sign-extended. `mem_dword` is 1 for double-word accesses.
- R3: Immediate 0x00/0x40/0x50/0xA0 store memory add/or/and/xor source. Bit 0 of the immediate may be set to request fetch. For word accesses only bits 31:0 of the source are used and only the addressed word changes.
- R4: With fetch set on a simple operation, the response has `rsp_src_we`=1 and `rsp_src_data` = old memory value, zero-extended for word accesses. With fetch clear, `rsp_src_we`=0.
- R5: Immediate 0xE1 (exchange) stores the source value and returns the old value on the source write-back.
- R6: Immediate 0xF1 (compare-exchange) compares memory with register zero (low 32 bits only for words). It writes the source value only when they are equal. It always sets `rsp_r0_we`=1 with the old value zero-extended, and never sets `rsp_src_we`.
- R7: Any other immediate value (including 0xE0, 0xF0 and any nonzero bits 31:8) sets `rsp_illegal`. It then requests no lock, makes no memory access and asserts no write-back.
- R8: Memory is accessed only while `lock_gnt` is high. `lock_req` stays high continuously from before the read until after the write, and is low while the response is offered.
- R9: `cmd_ready` is low from acceptance until the response handshake. `rsp_valid` and the response fields hold steady while `rsp_ready` is low.
- R10: After reset `cmd_ready`=1, `rsp_valid`=0, `lock_req`=0 and `mem_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted at this edge if valid |
| cmd_opcode | input | 8 | Instruction opcode byte |
| cmd_imm | input | 32 | Operation immediate |
| cmd_base | input | 64 | Base address (destination register) |
| cmd_offset | input | 16 | Signed displacement |
| cmd_src | input | 64 | Source register value |
| cmd_r0 | input | 64 | Register zero value |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_illegal | output | 1 | Encoding was illegal |
| rsp_src_we | output | 1 | Source register write-back enable |
| rsp_src_data | output | 64 | Source register write-back value |
| rsp_r0_we | output | 1 | Register zero write-back enable |
| rsp_r0_data | output | 64 | Register zero write-back value |
| lock_req | output | 1 | Memory lock request |
| lock_gnt | input | 1 | Memory lock granted |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_dword | output | 1 | 1 = 64-bit access, 0 = 32-bit |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after a read strobe |

## Verification
A competing requester adds one to a shared word again and again while the unit runs atomic adds on the same word. If the lock were dropped between read and write, one side's increment would be lost and the final count would come out short.

Word operations use source and register-zero values whose upper halves hold garbage. A design that mixed in bits 63:32 would corrupt the neighbouring word, return a fetched value that is not zero-extended, or fail a compare-exchange that should match.

The bench runs compare-exchange both with a match and with a miss. A wrong design would write memory on a miss or load the source register. The fetch-less exchange and compare encodings, and a bad size field, are also tried. Each must come back illegal with no lock cycles and no memory strobes.

// File: rtl/atom_pkg.sv
package atom_pkg;

  localparam logic [7:0] OPC_ATOM_WORD  = 8'hC3;
  localparam logic [7:0] OPC_ATOM_DWORD = 8'hDB;

  localparam logic [7:0] IMM_ADD  = 8'h00;
  localparam logic [7:0] IMM_OR   = 8'h40;
  localparam logic [7:0] IMM_AND  = 8'h50;
  localparam logic [7:0] IMM_XOR  = 8'hA0;
  localparam logic [7:0] IMM_XCHG = 8'hE1;
  localparam logic [7:0] IMM_CMPX = 8'hF1;

  typedef enum logic [2:0] {
    OP_ADD, OP_OR, OP_AND, OP_XOR, OP_XCHG, OP_CMPX
  } rmw_op_e;

  typedef struct packed {
    rmw_op_e op;
    logic    fetch;
    logic    dword;
    logic    illegal;
  } atom_ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOCK, ST_READ, ST_CALC, ST_WRITE, ST_RESP
  } seq_state_e;

endpackage

// File: rtl/atom_decode.sv
module atom_decode
  import atom_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [7:0]       opcode,
  input  logic [IMM_W-1:0] imm,
  output atom_ctl_t        ctl
);

  localparam int HI_W = IMM_W - 8;

  logic       opc_ok;
  logic       imm_hi_zero;
  logic [7:0] code;
  logic [7:0] code_nf;

  assign code        = imm[7:0];
  assign code_nf     = {code[7:1], 1'b0};
  assign imm_hi_zero = (imm[IMM_W-1:8] == {HI_W{1'b0}});
  assign opc_ok      = (opcode == OPC_ATOM_WORD) || (opcode == OPC_ATOM_DWORD);

  always_comb begin
    ctl.op      = OP_ADD;
    ctl.fetch   = code[0];
    ctl.dword   = (opcode == OPC_ATOM_DWORD);
    ctl.illegal = 1'b0;
    if (code == IMM_XCHG) begin
      ctl.op = OP_XCHG;
    end else if (code == IMM_CMPX) begin
      ctl.op = OP_CMPX;
    end else begin
      unique case (code_nf)
        IMM_ADD: ctl.op = OP_ADD;
        IMM_OR:  ctl.op = OP_OR;
        IMM_AND: ctl.op = OP_AND;
        IMM_XOR: ctl.op = OP_XOR;
        default: ctl.illegal = 1'b1;
      endcase
    end
    if (!opc_ok || !imm_hi_zero) ctl.illegal = 1'b1;
  end

endmodule

// File: rtl/atom_alu.sv
module atom_alu
  import atom_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  atom_ctl_t          ctl,
  input  logic [DATA_W-1:0]  old_raw,
  input  logic [DATA_W-1:0]  src_raw,
  input  logic [DATA_W-1:0]  r0_raw,
  output logic [DATA_W-1:0]  new_val,
  output logic [DATA_W-1:0]  old_ext,
  output logic               do_write
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] old_v;
  logic [DATA_W-1:0] src_v;
  logic [DATA_W-1:0] r0_v;

  function automatic logic [DATA_W-1:0] narrow(input logic [DATA_W-1:0] v, input logic wide);
    return wide ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  assign old_v   = narrow(old_raw, ctl.dword);
  assign src_v   = narrow(src_raw, ctl.dword);
  assign r0_v    = narrow(r0_raw, ctl.dword);
  assign old_ext = old_v;

  always_comb begin
    do_write = 1'b1;
    unique case (ctl.op)
      OP_ADD:  new_val = narrow(old_v + src_v, ctl.dword);
      OP_OR:   new_val = old_v | src_v;
      OP_AND:  new_val = old_v & src_v;
      OP_XOR:  new_val = old_v ^ src_v;
      OP_XCHG: new_val = src_v;
      OP_CMPX: begin
        new_val  = src_v;
        do_write = (old_v == r0_v);
      end
      default: begin
        new_val  = old_v;
        do_write = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/atom_seq.sv
module atom_seq
  import atom_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_illegal,
  input  logic lock_gnt,
  input  logic rsp_ready,
  input  logic wr_needed,
  output logic cmd_ready,
  output logic take_cmd,
  output logic take_result,
  output logic lock_req,
  output logic mem_en,
  output logic mem_we,
  output logic rsp_valid
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid) state_d = cmd_illegal ? ST_RESP : ST_LOCK;
      ST_LOCK:  if (lock_gnt) state_d = ST_READ;
      ST_READ:  state_d = ST_CALC;
      ST_CALC:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_RESP;
      ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cmd_ready   = (state_q == ST_IDLE);
  assign take_cmd    = cmd_ready && cmd_valid;
  assign take_result = (state_q == ST_CALC);
  assign lock_req    = (state_q == ST_LOCK) || (state_q == ST_READ) ||
                       (state_q == ST_CALC) || (state_q == ST_WRITE);
  assign mem_en      = (state_q == ST_READ) || ((state_q == ST_WRITE) && wr_needed);
  assign mem_we      = (state_q == ST_WRITE);
  assign rsp_valid   = (state_q == ST_RESP);

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atom_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_opcode,
  input  logic [IMM_W-1:0]  cmd_imm,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [OFF_W-1:0]  cmd_offset,
  input  logic [DATA_W-1:0] cmd_src,
  input  logic [DATA_W-1:0] cmd_r0,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_illegal,
  output logic              rsp_src_we,
  output logic [DATA_W-1:0] rsp_src_data,
  output logic              rsp_r0_we,
  output logic [DATA_W-1:0] rsp_r0_data,
  output logic              lock_req,
  input  logic              lock_gnt,
  output logic              mem_en,
  output logic              mem_we,
  output logic              mem_dword,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int EXT_W = ADDR_W - OFF_W;

  atom_ctl_t         ctl_in, ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q, r0_q;
  logic [DATA_W-1:0] new_val, old_ext;
  logic [DATA_W-1:0] new_q, old_q;
  logic              do_write, wr_q;
  logic              take_cmd, take_result;

  atom_decode #(.IMM_W(IMM_W)) u_dec (
    .opcode (cmd_opcode),
    .imm    (cmd_imm),
    .ctl    (ctl_in)
  );

  atom_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_illegal (ctl_in.illegal),
    .lock_gnt    (lock_gnt),
    .rsp_ready   (rsp_ready),
    .wr_needed   (wr_q),
    .cmd_ready   (cmd_ready),
    .take_cmd    (take_cmd),
    .take_result (take_result),
    .lock_req    (lock_req),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .rsp_valid   (rsp_valid)
  );

  atom_alu #(.DATA_W(DATA_W)) u_alu (
    .ctl      (ctl_q),
    .old_raw  (mem_rdata),
    .src_raw  (src_q),
    .r0_raw   (r0_q),
    .new_val  (new_val),
    .old_ext  (old_ext),
    .do_write (do_write)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      addr_q <= '0;
      src_q  <= '0;
      r0_q   <= '0;
    end else if (take_cmd) begin
      ctl_q  <= ctl_in;
      addr_q <= cmd_base + {{EXT_W{cmd_offset[OFF_W-1]}}, cmd_offset};
      src_q  <= cmd_src;
      r0_q   <= cmd_r0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_q <= '0;
      old_q <= '0;
      wr_q  <= 1'b0;
    end else if (take_cmd) begin
      wr_q  <= 1'b0;
    end else if (take_result) begin
      new_q <= new_val;
      old_q <= old_ext;
      wr_q  <= do_write;
    end
  end

  assign mem_addr     = addr_q;
  assign mem_dword    = ctl_q.dword;
  assign mem_wdata    = new_q;

  assign rsp_illegal  = ctl_q.illegal;
  assign rsp_src_we   = !ctl_q.illegal && ctl_q.fetch && (ctl_q.op != OP_CMPX);
  assign rsp_r0_we    = !ctl_q.illegal && (ctl_q.op == OP_CMPX);
  assign rsp_src_data = old_q;
  assign rsp_r0_data  = old_q;

endmodule

// File: rtl/atomic_rmw_unit_checker.sv
module atomic_rmw_unit_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_illegal,
  input logic              rsp_src_we,
  input logic              rsp_r0_we,
  input logic [DATA_W-1:0] rsp_src_data,
  input logic              lock_req,
  input logic              lock_gnt,
  input logic              mem_en,
  input logic              mem_we
);

  AST_MEM_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> lock_gnt) else $error("memory access without grant"); // R8

  AST_WRITE_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (lock_req && $past(lock_req))) else $error("write outside lock window"); // R8

  AST_LOCK_FREE_AT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !lock_req) else $error("lock held during response"); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_src_data))) else $error("response dropped"); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready) else $error("accepted while busy"); // R9

  AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> (!rsp_src_we && !rsp_r0_we)) else $error("write-back on illegal"); // R7

  AST_CMPX_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_r0_we |-> !rsp_src_we) else $error("both write-backs set"); // R6

endmodule

bind atomic_rmw_unit atomic_rmw_unit_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_illegal  (rsp_illegal),
  .rsp_src_we   (rsp_src_we),
  .rsp_r0_we    (rsp_r0_we),
  .rsp_src_data (rsp_src_data),
  .lock_req     (lock_req),
  .lock_gnt     (lock_gnt),
  .mem_en       (mem_en),
  .mem_we       (mem_we)
);

// File: tb/atomic_rmw_unit_test.sv
`timescale 1ns/1ps
module atomic_rmw_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [7:0]  cmd_opcode = '0;
  logic [31:0] cmd_imm = '0;
  logic [63:0] cmd_base = '0, cmd_src = '0, cmd_r0 = '0;
  logic [15:0] cmd_offset = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_illegal, rsp_src_we, rsp_r0_we;
  logic [63:0] rsp_src_data, rsp_r0_data;
  logic        lock_req, lock_gnt;
  logic        mem_en, mem_we, mem_dword;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  atomic_rmw_unit uut (.*);

  // shared memory: 16 words of 32 bits
  logic [31:0] mem_w [16];
  logic [1:0]  owner;
  logic        comp_req = 1'b0, comp_en = 1'b0, comp_we = 1'b0;
  logic [63:0] comp_addr = '0, comp_wdata = '0;
  logic        m_en, m_we, m_dw;
  logic [63:0] m_addr, m_wdata;

  assign lock_gnt = (owner == 2'd1);
  assign m_en    = (owner == 2'd1) ? mem_en    : (owner == 2'd2) ? comp_en : 1'b0;
  assign m_we    = (owner == 2'd1) ? mem_we    : comp_we;
  assign m_dw    = (owner == 2'd1) ? mem_dword : 1'b0;
  assign m_addr  = (owner == 2'd1) ? mem_addr  : comp_addr;
  assign m_wdata = (owner == 2'd1) ? mem_wdata : comp_wdata;

  always @(posedge clk) begin
    if (!rst_n) owner <= 2'd0;
    else if (owner == 2'd0) owner <= lock_req ? 2'd1 : (comp_req ? 2'd2 : 2'd0);
    else if (owner == 2'd1 && !lock_req) owner <= 2'd0;
    else if (owner == 2'd2 && !comp_req) owner <= 2'd0;
  end

  always @(posedge clk) begin
    if (m_en) begin
      if (m_dw) begin
        if (m_we) begin
          mem_w[{m_addr[5:3], 1'b0}] <= m_wdata[31:0];
          mem_w[{m_addr[5:3], 1'b1}] <= m_wdata[63:32];
        end else mem_rdata <= {mem_w[{m_addr[5:3], 1'b1}], mem_w[{m_addr[5:3], 1'b0}]};
      end else begin
        if (m_we) mem_w[m_addr[5:2]] <= m_wdata[31:0];
        else      mem_rdata <= {32'h0, mem_w[m_addr[5:2]]};
      end
    end
  end

  int uut_mem_cnt = 0, uut_lock_cnt = 0;
  always @(posedge clk) begin
    if (rst_n && mem_en) uut_mem_cnt <= uut_mem_cnt + 1;
    if (rst_n && lock_req) uut_lock_cnt <= uut_lock_cnt + 1;
  end

  int n_chk = 0, n_fail = 0, cycles = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  logic        r_ill, r_swe, r_rwe;
  logic [63:0] r_sd, r_rd;

  task automatic do_op(input logic [7:0] opc, input logic [31:0] imm, input logic [63:0] base,
                       input logic [15:0] off, input logic [63:0] src, input logic [63:0] r0,
                       input int hold);
    @(negedge clk);
    cmd_opcode = opc; cmd_imm = imm; cmd_base = base; cmd_offset = off;
    cmd_src = src; cmd_r0 = r0; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R9 response held", {62'h0, rsp_valid, cmd_ready}, 64'h2);
    end
    r_ill = rsp_illegal; r_swe = rsp_src_we; r_rwe = rsp_r0_we;
    r_sd = rsp_src_data; r_rd = rsp_r0_data;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 reset outputs", {60'h0, cmd_ready, rsp_valid, lock_req, mem_en}, 64'h8);
  endtask

  task automatic t_add_word();
    mem_w[4] = 32'hFFFF_FFFF; mem_w[5] = 32'hA5A5_A5A5;
    do_op(8'hC3, 32'h00, 64'h10, 16'h0, 64'h1234_5678_0000_0002, 64'h0, 0);
    chk("R3 word add wraps", {32'h0, mem_w[4]}, 64'h1);
    chk("R3 neighbour word untouched", {32'h0, mem_w[5]}, 64'hA5A5_A5A5);
    chk("R4 no fetch no src write", {62'h0, r_swe, r_rwe}, 64'h0);
  endtask

  task automatic t_or_dword_fetch();
    mem_w[8] = 32'h0000_00F0; mem_w[9] = 32'h0F0F_0000;
    do_op(8'hDB, 32'h41, 64'h28, 16'hFFF8, 64'hF000_0000_0000_000F, 64'h0, 0);
    chk("R2 R3 dword or negative offset", {mem_w[9], mem_w[8]}, 64'hFF0F_0000_0000_00FF);
    chk("R4 fetch old dword", r_sd, 64'h0F0F_0000_0000_00F0);
    chk("R4 fetch src we", {63'h0, r_swe}, 64'h1);
  endtask

  task automatic t_and_word_fetch();
    mem_w[2] = 32'hDEAD_BEEF;
    do_op(8'hC3, 32'h51, 64'h8, 16'h0, 64'hFFFF_FFFF_FFFF_0000, 64'h0, 0);
    chk("R3 word and", {32'h0, mem_w[2]}, 64'hDEAD_0000);
    chk("R4 fetched word zero-extended", r_sd, 64'h0000_0000_DEAD_BEEF);
  endtask

  task automatic t_xor_dword();
    mem_w[12] = 32'h1111_1111; mem_w[13] = 32'h2222_2222;
    do_op(8'hDB, 32'hA0, 64'h28, 16'h0008, 64'hFFFF_0000_FFFF_0000, 64'h0, 3);
    chk("R2 R3 dword xor positive offset", {mem_w[13], mem_w[12]}, 64'hDDDD_2222_EEEE_1111);
    chk("R4 xor no fetch", {63'h0, r_swe}, 64'h0);
  endtask

  task automatic t_xchg_word();
    mem_w[3] = 32'h7654_3210;
    do_op(8'hC3, 32'hE1, 64'hC, 16'h0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0, 0);
    chk("R5 exchange stores source", {32'h0, mem_w[3]}, 64'hCCCC_DDDD);
    chk("R5 exchange returns old", {r_swe, r_sd[62:0]}, {1'b1, 63'h0000_0000_7654_3210});
  endtask

  task automatic t_cmpx();
    mem_w[6] = 32'h89AB_CDEF; mem_w[7] = 32'h0123_4567;
    do_op(8'hDB, 32'hF1, 64'h18, 16'h0, 64'h5555_6666_7777_8888, 64'h0123_4567_89AB_CDEF, 0);
    chk("R6 dword match writes", {mem_w[7], mem_w[6]}, 64'h5555_6666_7777_8888);
    chk("R6 r0 old value", r_rd, 64'h0123_4567_89AB_CDEF);
    chk("R6 flags r0 only", {62'h0, r_swe, r_rwe}, 64'h1);
    mem_w[1] = 32'h8000_0001;
    do_op(8'hC3, 32'hF1, 64'h4, 16'h0, 64'h1, 64'hFFFF_FFFF_8000_0002, 0);
    chk("R6 word miss no write", {32'h0, mem_w[1]}, 64'h8000_0001);
    chk("R6 word r0 zero-extended", r_rd, 64'h0000_0000_8000_0001);
    do_op(8'hC3, 32'hF1, 64'h4, 16'h0, 64'h1, 64'hFFFF_FFFF_8000_0001, 0);
    chk("R6 word match ignores r0 upper", {32'h0, mem_w[1]}, 64'h1);
  endtask

  task automatic t_illegal();
    int m0, l0;
    mem_w[3] = 32'h1357_9BDF;
    m0 = uut_mem_cnt; l0 = uut_lock_cnt;
    do_op(8'hC3, 32'hE0, 64'hC, 16'h0, 64'h5, 64'h0, 0);
    chk("R7 fetchless exchange illegal", {61'h0, r_ill, r_swe, r_rwe}, 64'h4);
    do_op(8'hC3, 32'hF0, 64'hC, 16'h0, 64'h5, 64'h0, 0);
    chk("R7 fetchless compare illegal", {61'h0, r_ill, r_swe, r_rwe}, 64'h4);
    do_op(8'hC3, 32'h02, 64'hC, 16'h0, 64'h5, 64'h0, 0);
    chk("R7 unknown code illegal", {63'h0, r_ill}, 64'h1);
    do_op(8'hC3, 32'h100, 64'hC, 16'h0, 64'h5, 64'h0, 0);
    chk("R7 upper immediate bits illegal", {63'h0, r_ill}, 64'h1);
    do_op(8'hD3, 32'h00, 64'hC, 16'h0, 64'h5, 64'h0, 0);
    chk("R1 bad size opcode illegal", {63'h0, r_ill}, 64'h1);
    chk("R7 memory untouched", {32'h0, mem_w[3]}, 64'h1357_9BDF);
    chk("R7 no lock and no access", {uut_mem_cnt - m0, uut_lock_cnt - l0}, 64'h0);
    do_op(8'hC3, 32'h00, 64'hC, 16'h0, 64'h1, 64'h0, 0);
    chk("R1 word opcode legal", {31'h0, r_ill, mem_w[3]}, 64'h1357_9BE0);
  endtask

  task automatic t_contention();
    mem_w[14] = 32'h0;
    fork
      begin
        for (int i = 0; i < 20; i++) do_op(8'hC3, 32'h00, 64'h38, 16'h0, 64'h3, 64'h0, 0);
      end
      begin
        for (int k = 0; k < 20; k++) begin
          logic [31:0] v;
          @(negedge clk); comp_req = 1'b1;
          while (owner != 2'd2) @(negedge clk);
          comp_en = 1'b1; comp_we = 1'b0; comp_addr = 64'h38;
          @(negedge clk);
          v = mem_rdata[31:0];
          comp_we = 1'b1; comp_wdata = {32'h0, v + 32'd1};
          @(negedge clk);
          comp_en = 1'b0; comp_we = 1'b0; comp_req = 1'b0;
        end
      end
    join
    chk("R8 no lost update under contention", {32'h0, mem_w[14]}, 64'd80);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem_w[i] = 32'h0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add_word();
    t_or_dword_fetch();
    t_and_word_fetch();
    t_xor_dword();
    t_xchg_word();
    t_cmpx();
    t_illegal();
    t_contention();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule